// File: doc/BRIEF.md
# Seconds Clock Register Block with Dual Alarms

This block is the register side of a real-time clock. It keeps a 32-bit count of seconds that advances on a one-second tick strobe supplied from outside. Two compare registers watch that count. When the count steps onto a compare value, a sticky status bit records the event until software acknowledges it by writing a one to that bit. Each alarm has its own small interrupt configuration word. That word can forward the latched event to an interrupt line and can add a periodic interrupt paced by either the one-second strobe or a second, faster rate strobe.

Software reaches the block through a simple word-wide read/write port with byte offsets. After reset a configuration/test word holds a nonzero marker in its low byte, and the count stays frozen while that marker is there. Software starts the clock by writing zero to that word, sets the time, and then clears any stale alarm status. A correction word is stored and read back, but it does not act on the count here.

Top module: `rtc_alarm_regs`

## Requirements
- R1: After synchronous reset the time, status, both compare words, both interrupt configurations and the correction word read as 0, the config/test word reads 0x000000A5, and both irq outputs are low.
- R2: While config/test bits [7:0] are nonzero the time count ignores ticks. Once they are zero, each tick_1hz pulse adds exactly one to the count.
- R3: A write to offset 0x0C loads the count and wins over a tick in the same cycle. The count wraps from 0xFFFFFFFF to 0.
- R4: Status bit i (alarm 0 at bit 0, alarm 1 at bit 1) sets when a tick moves the count onto the value held at offset 0x10 + 4*i. It then stays set through further ticks.
- R5: Writing offset 0x00 clears each status bit whose data bit is 1 and leaves bits written 0 alone. A new match in the same cycle as its clear leaves the bit set.
- R6: irq[i] is high one cycle after status bit i and config bit 0 (alarm enable) at offset 0x04 + 4*i are both high. It drops one cycle after either goes low, unless a periodic pulse is active.
- R7: With config bit 1 (periodic enable) set, irq[i] pulses for one cycle, one cycle after each tick_1hz pulse if config bit 2 is 1, or after each per_tick pulse if bit 2 is 0. The unselected strobe has no effect.
- R8: Reads at unmapped or non-word-aligned offsets return 0. Writes there change no register.
- R9: Read data appears on rdata in the cycle after rd_en is sampled. The compare and correction words read back exactly what was written.
- R10: An interrupt configuration word reads back only bits [2:0]. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| per_tick | input | 1 | One-cycle strobe at the alternative periodic rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 2 | Per-alarm interrupt lines |

## Verification
The count is driven through three patterns. Ticks arrive while the uninitialised marker is present, which separates gating from counting. Ticks then run across the 32-bit wrap. A load and a tick land in the same cycle, which shows which one takes priority. The alarms are placed two seconds apart, so status bits that set one at a time can be told apart from bits that set together. Acknowledge writes with 0, single-bit and same-cycle-as-match patterns separate a true write-one-to-clear from a plain overwrite. Each periodic source is pulsed while the other is selected, so a swapped rate select shows up at the irq pins.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_AW  = 5;
  localparam int N_ALARM = 2;

  localparam logic [REG_AW-1:0] OFS_STATUS   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_IRQ_BASE = 5'h04;
  localparam logic [REG_AW-1:0] OFS_TIME     = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CMP_BASE = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CORR     = 5'h18;
  localparam logic [REG_AW-1:0] OFS_CFGTEST  = 5'h1C;

  typedef struct packed {
    logic per_1hz;   // bit 2: periodic source is the 1 Hz strobe
    logic per_en;    // bit 1: periodic interrupt enable
    logic al_en;     // bit 0: alarm interrupt enable
  } irq_cfg_t;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         stepped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stepped <= 1'b0;
    end else begin
      stepped <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (run && tick) begin
        cnt     <= cnt + 1'b1;
        stepped <= 1'b1;
      end
    end
  end

  assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load) |=> (cnt == $past(cnt) + 1'b1));
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         stepped,
  input  logic         cmp_we,
  input  logic         cfg_we,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  input  logic         tick_1hz,
  input  logic         per_tick,
  output logic [W-1:0] cmp_q,
  output irq_cfg_t     cfg_q,
  output logic         sts_q,
  output logic         irq_q
);
  logic hit;
  logic per_pulse;

  assign hit       = stepped && (cnt == cmp_q);
  assign per_pulse = cfg_q.per_en && (cfg_q.per_1hz ? tick_1hz : per_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      cfg_q <= '0;
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= wdata;
      if (cfg_we) cfg_q <= irq_cfg_t'(wdata[2:0]);
      if (hit)      sts_q <= 1'b1;
      else if (ack) sts_q <= 1'b0;
      irq_q <= (sts_q && cfg_q.al_en) || per_pulse;
    end
  end

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !ack) |=> sts_q);
  assert_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> !sts_q);
  assert_irq_on_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_q && cfg_q.al_en) |=> irq_q);
  assert_irq_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!sts_q && !cfg_q.per_en) |=> !irq_q);
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter logic [7:0] INIT_CODE = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_1hz,
  input  logic                 per_tick,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [N_ALARM-1:0]   irq
);
  localparam int CFG_PAD = DATA_W - 3;

  logic               aligned;
  logic               wr_ok;
  logic [DATA_W-1:0]  cnt;
  logic               stepped;
  logic [DATA_W-1:0]  cfgtest_q;
  logic [DATA_W-1:0]  corr_q;
  logic [DATA_W-1:0]  cmp_arr [N_ALARM];
  irq_cfg_t           cfg_arr [N_ALARM];
  logic [N_ALARM-1:0] sts;
  logic [DATA_W-1:0]  rd_mux;

  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;

  rtc_sec_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (cfgtest_q[7:0] == 8'h00),
    .tick     (tick_1hz),
    .load     (wr_ok && addr == OFS_TIME),
    .load_val (wdata),
    .cnt      (cnt),
    .stepped  (stepped)
  );

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    localparam logic [REG_AW-1:0] CMP_OFS = OFS_CMP_BASE + REG_AW'(4 * g);
    localparam logic [REG_AW-1:0] CFG_OFS = OFS_IRQ_BASE + REG_AW'(4 * g);
    rtc_alarm_unit #(.W(DATA_W)) u_alarm (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .stepped  (stepped),
      .cmp_we   (wr_ok && addr == CMP_OFS),
      .cfg_we   (wr_ok && addr == CFG_OFS),
      .wdata    (wdata),
      .ack      (wr_ok && addr == OFS_STATUS && wdata[g]),
      .tick_1hz (tick_1hz),
      .per_tick (per_tick),
      .cmp_q    (cmp_arr[g]),
      .cfg_q    (cfg_arr[g]),
      .sts_q    (sts[g]),
      .irq_q    (irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgtest_q <= {{(DATA_W-8){1'b0}}, INIT_CODE};
      corr_q    <= '0;
    end else if (wr_ok) begin
      if (addr == OFS_CFGTEST) cfgtest_q <= wdata;
      if (addr == OFS_CORR)    corr_q    <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (addr)
        OFS_STATUS:  rd_mux = {{(DATA_W-N_ALARM){1'b0}}, sts};
        OFS_TIME:    rd_mux = cnt;
        OFS_CORR:    rd_mux = corr_q;
        OFS_CFGTEST: rd_mux = cfgtest_q;
        default:     rd_mux = '0;
      endcase
      for (int i = 0; i < N_ALARM; i++) begin
        if (addr == OFS_CMP_BASE + REG_AW'(4 * i)) rd_mux = cmp_arr[i];
        if (addr == OFS_IRQ_BASE + REG_AW'(4 * i))
          rd_mux = {{CFG_PAD{1'b0}}, cfg_arr[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_unaligned_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !aligned) |=> (rdata == '0));
  assert_cfg_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_IRQ_BASE) |=> (rdata[DATA_W-1:3] == '0));
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_rtc_alarm_regs.sv
module tb_rtc_alarm_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        per_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;  // 125 MHz

  rtc_alarm_regs dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .per_tick(per_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare each returned read against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      applied++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_1hz();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic pulse_per();
    per_tick = 1'b1;
    @(negedge clk);
    per_tick = 1'b0;
  endtask

  task automatic irq_chk(input int idx, input logic e, input string t);
    applied++;
    if (irq[idx] !== e) begin
      bad++;
      $display("FAIL %s: irq[%0d]=%b expected=%b", t, idx, irq[idx], e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    irq_chk(0, 1'b0, "R1 irq0");
    irq_chk(1, 1'b0, "R1 irq1");
    rd_chk(5'h0C, 32'h0, "R1 time");
    rd_chk(5'h00, 32'h0, "R1 status");
    rd_chk(5'h1C, 32'h0000_00A5, "R1 cfgtest");
    rd_chk(5'h10, 32'h0, "R1 cmp0");
    rd_chk(5'h08, 32'h0, "R1 irqcfg1");
    rd_chk(5'h18, 32'h0, "R1 corr");

    // R2 frozen while uninitialised, then counting
    repeat (3) pulse_1hz();
    rd_chk(5'h0C, 32'h0, "R2 frozen");
    bus_wr(5'h1C, 32'h0);
    repeat (3) pulse_1hz();
    rd_chk(5'h0C, 32'h3, "R2 counting");

    // R3 load, wrap, load beats tick
    bus_wr(5'h0C, 32'hFFFF_FFFE);
    pulse_1hz();
    rd_chk(5'h0C, 32'hFFFF_FFFF, "R3 top");
    pulse_1hz();
    rd_chk(5'h0C, 32'h0, "R3 wrap");
    tick_1hz = 1'b1;
    bus_wr(5'h0C, 32'd100);
    tick_1hz = 1'b0;
    rd_chk(5'h0C, 32'd100, "R3 load wins");

    // R4 matches (clear stale status from the wrap first)
    bus_wr(5'h00, 32'h3);
    rd_chk(5'h00, 32'h0, "R5 clear both");
    bus_wr(5'h10, 32'd105);
    bus_wr(5'h14, 32'd107);
    repeat (5) pulse_1hz();
    idle(2);
    rd_chk(5'h00, 32'h1, "R4 alarm0 only");
    irq_chk(0, 1'b0, "R6 disabled");
    repeat (2) pulse_1hz();
    idle(2);
    rd_chk(5'h00, 32'h3, "R4 both");
    pulse_1hz();
    idle(2);
    rd_chk(5'h00, 32'h3, "R4 sticky");

    // R5 write-one-to-clear
    bus_wr(5'h00, 32'h0);
    rd_chk(5'h00, 32'h3, "R5 zero write");
    bus_wr(5'h00, 32'h1);
    rd_chk(5'h00, 32'h2, "R5 clear bit0");
    bus_wr(5'h00, 32'h2);
    rd_chk(5'h00, 32'h0, "R5 clear bit1");
    bus_wr(5'h0C, 32'd200);
    bus_wr(5'h10, 32'd201);
    pulse_1hz();
    bus_wr(5'h00, 32'h1);
    rd_chk(5'h00, 32'h1, "R5 set wins");
    bus_wr(5'h00, 32'h1);
    rd_chk(5'h00, 32'h0, "R5 cleared");

    // R6 alarm interrupt
    bus_wr(5'h04, 32'h1);
    idle(2);
    irq_chk(0, 1'b0, "R6 no status");
    bus_wr(5'h0C, 32'd300);
    bus_wr(5'h10, 32'd301);
    pulse_1hz();
    idle(2);
    irq_chk(0, 1'b1, "R6 raised");
    bus_wr(5'h04, 32'h0);
    idle(1);
    irq_chk(0, 1'b0, "R6 disable drops");
    bus_wr(5'h04, 32'h1);
    idle(1);
    irq_chk(0, 1'b1, "R6 re-enabled");
    bus_wr(5'h00, 32'h1);
    idle(1);
    irq_chk(0, 1'b0, "R6 ack drops");
    bus_wr(5'h04, 32'h0);

    // R7 periodic interrupt, source select
    bus_wr(5'h08, 32'h6);
    pulse_per();
    irq_chk(1, 1'b0, "R7 per_tick ignored");
    idle(1);
    irq_chk(1, 1'b0, "R7 per_tick ignored late");
    pulse_1hz();
    irq_chk(1, 1'b1, "R7 1hz pulse");
    idle(1);
    irq_chk(1, 1'b0, "R7 1hz one cycle");
    bus_wr(5'h08, 32'h2);
    pulse_1hz();
    irq_chk(1, 1'b0, "R7 1hz ignored");
    pulse_per();
    irq_chk(1, 1'b1, "R7 per pulse");
    idle(1);
    irq_chk(1, 1'b0, "R7 per one cycle");
    bus_wr(5'h08, 32'h0);

    // R8 unmapped and misaligned
    rd_chk(5'h02, 32'h0, "R8 misaligned read");
    rd_chk(5'h1E, 32'h0, "R8 misaligned high");
    bus_wr(5'h06, 32'hFFFF_FFFF);
    rd_chk(5'h04, 32'h0, "R8 write ignored");
    bus_wr(5'h1D, 32'hFF);
    rd_chk(5'h1C, 32'h0, "R8 cfgtest untouched");

    // R9 / R10 readback
    bus_wr(5'h08, 32'hFFFF_FFFF);
    rd_chk(5'h08, 32'h7, "R10 cfg bits");
    bus_wr(5'h08, 32'h0);
    rd_chk(5'h14, 32'd107, "R9 cmp1");
    bus_wr(5'h18, 32'h1234_5678);
    rd_chk(5'h18, 32'h1234_5678, "R9 corr");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule